// File: doc/BRIEF.md
# Command Packet Segmenter

The segmenter takes one outgoing command message as a byte stream and cuts it into short link packets for a narrow radio transport. Every packet opens with a four-byte header (a fixed marker, a status byte, the command's sequence byte and the payload length) and carries between one and sixteen payload bytes. The status byte holds a fixed direction bit, a flag that tells the receiver more packets of the same command follow, and a five-bit packet counter.

Message bytes enter on a valid/ready stream that carries first and last markers and the command sequence value. The block gathers up to sixteen bytes in a local buffer, so the length byte is always known before the header goes out. It then plays the packet out on a second valid/ready stream that marks the first and last byte of each packet. Input is paused while a packet is sent. A message of zero length is given as a single beat with the no-data flag set, and it produces no packet.

Top module: `cmd_pkt_segmenter`

## Requirements
- R1: The first byte of every packet is 0xCD, and out_sop is high on that byte only.
- R2: The second byte of a packet equals 0x40 ORed with the five-bit packet counter in bits 4..0, with bit 5 (0x20) set when more packets of the same command follow.
- R3: The third byte of every packet is the in_cmd_seq value captured on the beat that carried in_first. It is the same in every packet of that message.
- R4: The fourth byte is the payload length N, with 1 <= N <= 16. It is followed by exactly N payload bytes in input order. out_eop is high on the last payload byte, so a packet is at most 20 bytes long.
- R5: The packet counter is 0 in the first packet of each message, rises by one for each later packet, and wraps from 31 to 0.
- R6: Bit 5 of the status byte is set if and only if more than 16 message bytes remain at the start of that packet. Every packet but the last of a message carries 16 payload bytes.
- R7: A message given as one beat with in_first, in_last and in_nodata all high emits no byte. The message after it still starts with packet counter 0.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop hold their values. No byte is lost or repeated.
- R9: After reset, out_valid is low and in_ready is high. in_ready stays low while a packet is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message beat offered |
| in_ready | output | 1 | Segmenter accepts a message beat |
| in_data | input | 8 | Message byte |
| in_first | input | 1 | Beat is the first of a message |
| in_last | input | 1 | Beat is the last of a message |
| in_nodata | input | 1 | Beat carries no byte (zero-length message) |
| in_cmd_seq | input | 8 | Command sequence value, captured with in_first |
| out_valid | output | 1 | Packet byte offered |
| out_ready | input | 1 | Consumer takes the packet byte |
| out_data | output | 8 | Packet byte |
| out_sop | output | 1 | Byte is the first of a packet |
| out_eop | output | 1 | Byte is the last of a packet |

## Verification
The hardest state to reach from the ports is the wrap of the five-bit packet counter. It only shows up in the 33rd packet of a single message, so the stimulus includes a 520-byte message that goes through the wrap and ends with a short packet. The sweep over every message length from 0 to 40 covers lengths exactly at and just past each 16-byte boundary, where the follow flag must drop or stay set. It also places zero-length messages between normal ones. Four consumer stall patterns, including heavy stalls, are rotated across the messages, so holds fall on header bytes, payload bytes and the final byte of a packet.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int BYTE_W      = 8;
    localparam int PAY_MAX_DEF = 16;
    localparam int HDR_LEN     = 4;
    localparam int PSEQ_W      = 5;

    localparam logic [BYTE_W-1:0] START_BYTE = 8'hCD;
    localparam logic [BYTE_W-1:0] STAT_BASE  = 8'h40;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_SEND = 1'b1
    } seg_state_e;

    typedef struct packed {
        logic              more;
        logic [PSEQ_W-1:0] pseq;
        logic [BYTE_W-1:0] cseq;
        logic [BYTE_W-1:0] plen;
    } seg_hdr_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic more,
                                                      input logic [PSEQ_W-1:0] pseq);
        return STAT_BASE | {2'b00, more, pseq};
    endfunction

endpackage

// File: rtl/seg_chunk_buf.sv
module seg_chunk_buf #(
    parameter int PAY_MAX = seg_pkg::PAY_MAX_DEF,
    parameter int CNT_W   = $clog2(PAY_MAX + 1),
    parameter int IDX_W   = $clog2(PAY_MAX + seg_pkg::HDR_LEN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [seg_pkg::BYTE_W-1:0] wr_data,
    input  logic                       clr,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [seg_pkg::BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]           count
);
    import seg_pkg::*;

    logic [BYTE_W-1:0] slot_q [PAY_MAX];
    logic [CNT_W-1:0]  count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (wr_en) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < PAY_MAX; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (wr_en && !clr && count_q == CNT_W'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < PAY_MAX; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = slot_q[k];
        end
    end

    assign count = count_q;

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> count_q < CNT_W'(PAY_MAX)) else $error("buffer overfill"); // R4

endmodule

// File: rtl/seg_hdr_mux.sv
module seg_hdr_mux #(
    parameter int IDX_W = $clog2(seg_pkg::PAY_MAX_DEF + seg_pkg::HDR_LEN)
) (
    input  logic [IDX_W-1:0]           tx_idx,
    input  seg_pkg::seg_hdr_t          hdr,
    input  logic [seg_pkg::BYTE_W-1:0] pay_byte,
    output logic [IDX_W-1:0]           rd_idx,
    output logic [seg_pkg::BYTE_W-1:0] out_data
);
    import seg_pkg::*;

    assign rd_idx = tx_idx - IDX_W'(HDR_LEN);

    always_comb begin
        if (tx_idx == IDX_W'(0))      out_data = START_BYTE;
        else if (tx_idx == IDX_W'(1)) out_data = status_byte(hdr.more, hdr.pseq);
        else if (tx_idx == IDX_W'(2)) out_data = hdr.cseq;
        else if (tx_idx == IDX_W'(3)) out_data = hdr.plen;
        else                          out_data = pay_byte;
    end

endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl #(
    parameter int PAY_MAX = seg_pkg::PAY_MAX_DEF,
    parameter int CNT_W   = $clog2(PAY_MAX + 1),
    parameter int IDX_W   = $clog2(PAY_MAX + seg_pkg::HDR_LEN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_first,
    input  logic                       in_last,
    input  logic                       in_nodata,
    input  logic [seg_pkg::BYTE_W-1:0] in_cmd_seq,
    output logic                       in_ready,
    input  logic [CNT_W-1:0]           buf_count,
    output logic                       buf_wr,
    output logic                       buf_clr,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic                       out_sop,
    output logic                       out_eop,
    output logic [IDX_W-1:0]           tx_idx,
    output seg_pkg::seg_hdr_t          hdr
);
    import seg_pkg::*;

    seg_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  len_q;
    logic              more_q;
    logic [PSEQ_W-1:0] pseq_q;
    logic [BYTE_W-1:0] cseq_q;

    logic             accept, wr, close, fire_end;
    logic [CNT_W-1:0] cnt_next;
    logic [IDX_W-1:0] last_idx;

    assign accept   = in_valid && (state_q == ST_FILL);
    assign wr       = accept && !in_nodata;
    assign cnt_next = buf_count + CNT_W'(wr);
    assign close    = accept && (in_last || (wr && buf_count == CNT_W'(PAY_MAX - 1)));
    assign last_idx = IDX_W'(len_q) + IDX_W'(HDR_LEN - 1);
    assign fire_end = (state_q == ST_SEND) && out_ready && (idx_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            idx_q   <= '0;
            len_q   <= '0;
            more_q  <= 1'b0;
            pseq_q  <= '0;
            cseq_q  <= '0;
        end else begin
            if (accept && in_first) cseq_q <= in_cmd_seq;
            case (state_q)
                ST_FILL: begin
                    if (close) begin
                        if (cnt_next == '0) begin
                            pseq_q <= '0;
                        end else begin
                            state_q <= ST_SEND;
                            len_q   <= cnt_next;
                            more_q  <= !in_last;
                            idx_q   <= '0;
                        end
                    end
                end
                ST_SEND: begin
                    if (out_ready) begin
                        if (idx_q == last_idx) begin
                            state_q <= ST_FILL;
                            pseq_q  <= more_q ? pseq_q + PSEQ_W'(1) : '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_FILL;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_FILL);
    assign buf_wr    = wr;
    assign buf_clr   = fire_end;
    assign out_valid = (state_q == ST_SEND);
    assign out_sop   = out_valid && (idx_q == '0);
    assign out_eop   = out_valid && (idx_q == last_idx);
    assign tx_idx    = idx_q;
    assign hdr       = '{more: more_q, pseq: pseq_q, cseq: cseq_q, plen: BYTE_W'(len_q)};

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND) |-> (len_q >= CNT_W'(1) && len_q <= CNT_W'(PAY_MAX))) else $error("bad length"); // R4

    AST_MORE_FULL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND && more_q) |-> (len_q == CNT_W'(PAY_MAX))) else $error("short packet with follow flag"); // R6

    AST_PSEQ_RESTART: assert property (@(posedge clk) disable iff (rst)
        (fire_end && !more_q) |=> (pseq_q == '0)) else $error("packet counter not restarted"); // R5

endmodule

// File: rtl/cmd_pkt_segmenter.sv
module cmd_pkt_segmenter #(
    parameter int PAY_MAX = seg_pkg::PAY_MAX_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_first,
    input  logic       in_last,
    input  logic       in_nodata,
    input  logic [7:0] in_cmd_seq,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sop,
    output logic       out_eop
);
    import seg_pkg::*;

    localparam int CNT_W = $clog2(PAY_MAX + 1);
    localparam int IDX_W = $clog2(PAY_MAX + HDR_LEN);

    logic [CNT_W-1:0]  buf_count;
    logic              buf_wr, buf_clr;
    logic [IDX_W-1:0]  tx_idx, rd_idx;
    logic [BYTE_W-1:0] pay_byte;
    seg_hdr_t          hdr;

    seg_ctrl #(.PAY_MAX(PAY_MAX), .CNT_W(CNT_W), .IDX_W(IDX_W)) ctrl_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_nodata(in_nodata), .in_cmd_seq(in_cmd_seq), .in_ready(in_ready),
        .buf_count(buf_count), .buf_wr(buf_wr), .buf_clr(buf_clr),
        .out_ready(out_ready), .out_valid(out_valid), .out_sop(out_sop),
        .out_eop(out_eop), .tx_idx(tx_idx), .hdr(hdr)
    );

    seg_chunk_buf #(.PAY_MAX(PAY_MAX), .CNT_W(CNT_W), .IDX_W(IDX_W)) buf_i (
        .clk(clk), .rst(rst),
        .wr_en(buf_wr), .wr_data(in_data), .clr(buf_clr),
        .rd_idx(rd_idx), .rd_data(pay_byte), .count(buf_count)
    );

    seg_hdr_mux #(.IDX_W(IDX_W)) mux_i (
        .tx_idx(tx_idx), .hdr(hdr), .pay_byte(pay_byte),
        .rd_idx(rd_idx), .out_data(out_data)
    );

    AST_START_MARK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> (out_data == START_BYTE)) else $error("bad start byte"); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))) else $error("output changed under stall"); // R8

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)) else $error("input accepted during send"); // R9

endmodule

// File: tb/cmd_pkt_segmenter_tb.sv
`timescale 1ns/100ps
module cmd_pkt_segmenter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_nodata = 1'b0;
    logic [7:0] in_data = '0, in_cmd_seq = '0;
    logic       in_ready;
    logic       out_valid, out_sop, out_eop;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int rmode    = 0;
    int rcnt     = 0;

    always #2.5 clk = ~clk;

    cmd_pkt_segmenter dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .in_nodata(in_nodata),
        .in_cmd_seq(in_cmd_seq),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pay(input int m, input int i);
        return 8'((m * 29 + i * 7 + 3) & 255);
    endfunction

    function automatic logic rdy_pat();
        rcnt++;
        case (rmode)
            0:       return 1'b1;
            1:       return (rcnt % 3) != 2;
            2:       return rcnt[0];
            default: return (rcnt % 7) < 2;
        endcase
    endfunction

    task automatic send_msg(input int m, input int len, input logic [7:0] cs);
        logic acc;
        if (len == 0) begin
            in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1; in_nodata = 1'b1;
            in_data = 8'h00; in_cmd_seq = cs;
            do begin
                acc = in_ready;
                @(negedge clk);
            end while (!acc);
        end else begin
            for (int i = 0; i < len; i++) begin
                if (rmode != 0 && (i % 5) == 3) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1; in_first = (i == 0); in_last = (i == len - 1);
                in_nodata = 1'b0; in_data = pay(m, i); in_cmd_seq = cs;
                do begin
                    acc = in_ready;
                    @(negedge clk);
                end while (!acc);
            end
        end
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_nodata = 1'b0;
    endtask

    task automatic recv_msg(input int m, input int len, input logic [7:0] cs);
        int npk, rem, plen;
        bit more;
        logic [7:0] e, held;
        string tag;
        if (len == 0) begin
            for (int c = 0; c < 12; c++) begin
                chk(out_valid == 1'b0, "R7 no output for empty message", int'(out_valid), 0);
                @(negedge clk);
            end
        end else begin
            npk = (len + 15) / 16;
            for (int k = 0; k < npk; k++) begin
                rem  = len - 16 * k;
                plen = (rem > 16) ? 16 : rem;
                more = (rem > 16);
                for (int j = 0; j < plen + 4; j++) begin
                    if (j == 0)      begin e = 8'hCD; tag = "R1 start byte"; end
                    else if (j == 1) begin e = 8'h40 | (more ? 8'h20 : 8'h00) | 8'(k % 32); tag = "R2 R5 R6 status byte"; end
                    else if (j == 2) begin e = cs; tag = "R3 command sequence"; end
                    else if (j == 3) begin e = 8'(plen); tag = "R4 length byte"; end
                    else             begin e = pay(m, 16 * k + j - 4); tag = "R4 payload byte"; end
                    forever begin
                        out_ready = rdy_pat();
                        if (out_valid && out_ready) begin
                            chk(out_data == e, tag, int'(out_data), int'(e));
                            chk(out_sop == (j == 0), "R1 sop marker", int'(out_sop), int'(j == 0));
                            chk(out_eop == (j == plen + 3), "R4 eop marker", int'(out_eop), int'(j == plen + 3));
                            if (j == 0) chk(in_ready == 1'b0, "R9 input paused during send", int'(in_ready), 0);
                            @(negedge clk);
                            break;
                        end else if (out_valid) begin
                            held = out_data;
                            @(negedge clk);
                            chk(out_valid && out_data == held, "R8 hold under stall", int'(out_data), int'(held));
                        end else begin
                            @(negedge clk);
                        end
                    end
                end
            end
        end
        out_ready = 1'b0;
    endtask

    task automatic run_msg(input int m, input int len, input logic [7:0] cs);
        fork
            send_msg(m, len, cs);
            recv_msg(m, len, cs);
        join
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);

        for (int len = 0; len <= 40; len++) begin
            rmode = len % 4;
            run_msg(len, len, 8'((len * 13 + 5) & 255));
        end
        // long message: packet counter wraps (R5)
        rmode = 1;
        run_msg(100, 520, 8'hA7);
        // empty message between normal ones (R7)
        rmode = 2;
        run_msg(101, 0, 8'h11);
        run_msg(102, 17, 8'h22);
        rmode = 3;
        run_msg(103, 0, 8'h33);
        run_msg(104, 33, 8'hFE);

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle after traffic", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 ready after traffic", int'(in_ready), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule